// File: doc/BRIEF.md
# Gated 16-bit Timer Channel

This block is one channel of a programmable interval timer. A 16-bit count advances on a chosen time base: the bus clock taken directly, the bus clock divided by 16 or by 256, or one step per rising edge of the horizontal-blank input. Both blanking inputs can be used as a gate. The gate can pause and resume the count, or it can clear the count and restart it on a blanking edge.

The channel compares the count against a target and also detects when the count wraps past 0xFFFF. Each event can set a sticky status flag and raise a one-cycle interrupt pulse. A flag is cleared by writing 1 to its bit. The target can return the count to zero, which makes the channel a periodic tick source.

Four registers sit on a simple synchronous port. Index 0 is the count, 1 is the control word, 2 is the target and 3 is a spare hold word. Writes take effect at the clock edge. Reads are combinational.

Top module: `gtmr_channel`

## Requirements
- R1: The clock-select field, control bits 1:0, picks the count step. Value 0 steps on every clock. Value 1 steps once per 16 clocks and value 2 once per 256 clocks, both counted from the last control write. Value 3 steps once per rising edge of `hblank`.
- R2: The count advances only while run bit 7 is 1. While it is 0, the count holds its value.
- R3: A control write stores bits 9:0 as written. Bit 10 is the target flag and bit 11 the overflow flag. Writing 1 to a flag bit clears that flag, and writing 0 leaves it as it is. A write never sets a flag.
- R4: Gate style 0 (bits 5:4 = 0) needs gate enable (bit 2) set. It stops counting at a rising edge of the gate source and resumes at a falling edge. The source is `vblank` when bit 3 is 1 and `hblank` when bit 3 is 0. The count is held while stopped.
- R5: Gate style 1 clears the count and starts counting at a rising edge of the gate source. Style 2 does this at a falling edge, and style 3 at both edges.
- R6: A control write that turns gating on clears the count and suspends counting until the first edge that the gate style acts on.
- R7: When the gate source is `hblank` and the clock select is 3, gate enable has no effect, and the channel counts `hblank` edges as an ungated counter.
- R8: An armed target fires when a step brings the count to a value greater than or equal to the target. If target-interrupt bit 8 is set, the target flag is set and `irq` pulses. If zero-return bit 6 is also set, the target is subtracted from the count. When bit 8 is clear, there is no flag, no pulse and no subtraction.
- R9: A target that has fired stays disarmed until the next wrap, unless zero-return applied. Writing a target that is less than or equal to the count disarms it. Writing a count that is greater than the target also disarms it.
- R10: A step from 0xFFFF wraps the count to 0 and re-arms the target. If overflow-interrupt bit 9 is set, the wrap also sets the overflow flag and pulses `irq`.
- R11: After reset the count, control and hold words are 0 and the target is 0xFFFF. The hold word reads back as written. Every read has bits 31:16 equal to 0.
- R12: `irq` is high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register index: 0 count, 1 control, 2 target, 3 hold |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| hblank | input | 1 | Horizontal blanking level |
| vblank | input | 1 | Vertical blanking level |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest state to reach from the ports is a target that is already behind the count but still deferred. The bench builds it with ordered writes while the channel is stopped: it writes the count first and the target second, or the reverse. It then restarts counting and checks that nothing fires until the count crosses a target that was written ahead of it. The wrap case is reached by preloading the count just below 0xFFFF with a small target. This shows the overflow firing first and the re-armed target firing five steps later.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    typedef enum logic [1:0] {
        ADDR_COUNT  = 2'd0,
        ADDR_MODE   = 2'd1,
        ADDR_TARGET = 2'd2,
        ADDR_HOLD   = 2'd3
    } addr_e;

    typedef enum logic [1:0] {
        SRC_DIV1   = 2'd0,
        SRC_DIVA   = 2'd1,
        SRC_DIVB   = 2'd2,
        SRC_HBLANK = 2'd3
    } clksel_e;

    typedef enum logic [1:0] {
        GM_LOW   = 2'd0,
        GM_START = 2'd1,
        GM_END   = 2'd2,
        GM_BOTH  = 2'd3
    } gmode_e;

    // control word bits 9:0, MSB first
    typedef struct packed {
        logic    ovf_ie;   // 9
        logic    tgt_ie;   // 8
        logic    enable;   // 7
        logic    zret;     // 6
        gmode_e  gmode;    // 5:4
        logic    gsrc;     // 3  (1 = vblank)
        logic    gate_en;  // 2
        clksel_e csel;     // 1:0
    } mode_t;

    localparam int MODE_W   = 10;
    localparam int TFLAG_B  = 10;
    localparam int OFLAG_B  = 11;
    localparam int GSRC_N   = 2;   // index 0 hblank, 1 vblank

    function automatic logic gate_active(input mode_t m);
        return m.gate_en && !(m.gsrc == 1'b0 && m.csel == SRC_HBLANK);
    endfunction

endpackage

// File: rtl/gtmr_edge.sv
module gtmr_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] lvl_d, lvl_q;

    always_comb lvl_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] = lvl[i] & ~lvl_q[i];
        assign fall[i] = ~lvl[i] & lvl_q[i];
    end
endmodule

// File: rtl/gtmr_prescale.sv
module gtmr_prescale
    import gtmr_pkg::*;
#(
    parameter int DIV_A_LOG2 = 4,
    parameter int DIV_B_LOG2 = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  clksel_e sel,
    input  logic    hb_rise,
    output logic    tick
);
    logic [DIV_B_LOG2-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = clr ? '0 : pre_q + 1'b1;
        unique case (sel)
            SRC_DIV1:   tick = 1'b1;
            SRC_DIVA:   tick = &pre_q[DIV_A_LOG2-1:0];
            SRC_DIVB:   tick = &pre_q;
            SRC_HBLANK: tick = hb_rise;
            default:    tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/gtmr_gate.sv
module gtmr_gate
    import gtmr_pkg::*;
(
    input  mode_t             mode,
    input  logic [GSRC_N-1:0] rise,
    input  logic [GSRC_N-1:0] fall,
    output logic              g_reset,
    output logic              g_stop,
    output logic              g_resume
);
    logic r, f;

    always_comb begin
        r        = rise[mode.gsrc];
        f        = fall[mode.gsrc];
        g_reset  = 1'b0;
        g_stop   = 1'b0;
        g_resume = 1'b0;
        if (gate_active(mode)) begin
            unique case (mode.gmode)
                GM_LOW:   begin g_stop = r; g_resume = f; end
                GM_START: g_reset = r;
                GM_END:   g_reset = f;
                GM_BOTH:  g_reset = r | f;
                default:  g_reset = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gtmr_channel.sv
module gtmr_channel
    import gtmr_pkg::*;
#(
    parameter int CW         = 16,
    parameter int DIV_A_LOG2 = 4,
    parameter int DIV_B_LOG2 = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        hblank,
    input  logic        vblank,
    output logic        irq
);
    localparam int PAD = 32 - CW;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] tgt;
        logic [CW-1:0] hold;
        mode_t         mode;
        logic          tflag;
        logic          oflag;
        logic          armed;
        logic          run;
        logic          irq;
    } state_t;

    state_t s_d, s_q;

    logic [GSRC_N-1:0] rise, fall;
    logic              tick, g_reset, g_stop, g_resume, mode_wr;
    logic [CW:0]       inc;
    mode_t             wmode;
    logic [CW-1:0]     wval;

    assign wmode   = mode_t'(reg_wdata[MODE_W-1:0]);
    assign wval    = reg_wdata[CW-1:0];
    assign mode_wr = reg_wr && (addr_e'(reg_addr) == ADDR_MODE);

    gtmr_edge #(.N(GSRC_N)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({vblank, hblank}),
        .rise (rise),
        .fall (fall)
    );

    gtmr_prescale #(.DIV_A_LOG2(DIV_A_LOG2), .DIV_B_LOG2(DIV_B_LOG2)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (mode_wr),
        .sel    (s_q.mode.csel),
        .hb_rise(rise[0]),
        .tick   (tick)
    );

    gtmr_gate u_gate (
        .mode    (s_q.mode),
        .rise    (rise),
        .fall    (fall),
        .g_reset (g_reset),
        .g_stop  (g_stop),
        .g_resume(g_resume)
    );

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        inc     = {1'b0, s_q.cnt} + 1'b1;
        if (reg_wr) begin
            unique case (addr_e'(reg_addr))
                ADDR_COUNT: begin
                    s_d.cnt   = wval;
                    s_d.armed = !(wval > s_q.tgt);
                end
                ADDR_MODE: begin
                    s_d.mode  = wmode;
                    s_d.tflag = s_q.tflag & ~reg_wdata[TFLAG_B];
                    s_d.oflag = s_q.oflag & ~reg_wdata[OFLAG_B];
                    if (gate_active(wmode)) begin
                        s_d.cnt = '0;
                        s_d.run = 1'b0;
                    end else begin
                        s_d.run = 1'b1;
                    end
                end
                ADDR_TARGET: begin
                    s_d.tgt   = wval;
                    s_d.armed = wval > s_q.cnt;
                end
                ADDR_HOLD: s_d.hold = wval;
                default: s_d.hold = s_q.hold;
            endcase
        end else if (s_q.mode.enable) begin
            if (g_reset) begin
                s_d.cnt   = '0;
                s_d.armed = 1'b1;
                s_d.run   = 1'b1;
            end else if (g_stop) begin
                s_d.run = 1'b0;
            end else if (g_resume) begin
                s_d.run = 1'b1;
            end else if (s_q.run && tick) begin
                if (inc[CW]) begin
                    s_d.cnt   = '0;
                    s_d.armed = 1'b1;
                    if (s_q.mode.ovf_ie) begin
                        s_d.oflag = 1'b1;
                        s_d.irq   = 1'b1;
                    end
                end else if (s_q.armed && (inc[CW-1:0] >= s_q.tgt)) begin
                    if (s_q.mode.tgt_ie) begin
                        s_d.tflag = 1'b1;
                        s_d.irq   = 1'b1;
                        if (s_q.mode.zret) begin
                            s_d.cnt = inc[CW-1:0] - s_q.tgt;
                        end else begin
                            s_d.cnt   = inc[CW-1:0];
                            s_d.armed = 1'b0;
                        end
                    end else begin
                        s_d.cnt   = inc[CW-1:0];
                        s_d.armed = 1'b0;
                    end
                end else begin
                    s_d.cnt = inc[CW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.tgt   <= '1;
            s_q.armed <= 1'b1;
            s_q.run   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (addr_e'(reg_addr))
            ADDR_COUNT:  reg_rdata = {{PAD{1'b0}}, s_q.cnt};
            ADDR_MODE:   reg_rdata = {20'd0, s_q.oflag, s_q.tflag, s_q.mode};
            ADDR_TARGET: reg_rdata = {{PAD{1'b0}}, s_q.tgt};
            ADDR_HOLD:   reg_rdata = {{PAD{1'b0}}, s_q.hold};
            default:     reg_rdata = '0;
        endcase
    end

    assign irq = s_q.irq;

    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (s_q.tflag || s_q.oflag)); // R12
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.mode.enable && !reg_wr) |=> $stable(s_q.cnt)); // R2
    AST_WRITE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (!$rose(s_q.tflag) && !$rose(s_q.oflag))); // R3
    AST_WRAP_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.oflag) |-> ($past(s_q.cnt) == {CW{1'b1}} && s_q.cnt == '0)); // R10
    AST_TARGET_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.tflag) && !s_q.mode.zret) |-> (s_q.cnt >= s_q.tgt)); // R8
    AST_GATE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && gate_active(wmode)) |=> (s_q.cnt == '0 && !s_q.run)); // R6
endmodule

// File: tb/gtmr_channel_test.sv
module gtmr_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hblank = 1'b0;
    logic        vblank = 1'b0;
    logic        irq;

    int n_chk = 0, n_fail = 0, irq_cnt = 0;
    logic [31:0] rv;

    gtmr_channel uut (.*);

    always #10 clk = ~clk;

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hb_pulse();
        hblank = 1'b1; @(negedge clk);
        hblank = 1'b0; @(negedge clk);
    endtask

    localparam logic [31:0] EN = 32'h080, TIE = 32'h100, OIE = 32'h200, ZR = 32'h040;
    localparam logic [31:0] GEN = 32'h004, GVB = 32'h008;

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int exp_g [4][4];
        exp_g[0] = '{0, 0, 5, 5};
        exp_g[1] = '{0, 5, 11, 5};
        exp_g[2] = '{0, 0, 5, 11};
        exp_g[3] = '{0, 5, 5, 5};

        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset values
        rd(0, rv); check("R11 count reset", rv, 32'h0);
        rd(1, rv); check("R11 mode reset", rv, 32'h0);
        rd(2, rv); check("R11 target reset", rv, 32'h0000FFFF);
        rd(3, rv); check("R11 hold reset", rv, 32'h0);
        wr(3, 32'hDEAD_BEEF);
        rd(3, rv); check("R11 hold readback", rv, 32'h0000BEEF);
        wr(0, 32'hFFFF_1234);
        rd(0, rv); check("R11 upper zero", rv, 32'h00001234);

        // R1 prescale sweep
        for (int cs = 0; cs < 3; cs++) begin
            for (int j = 0; j < 9; j++) begin
                int ks [9] = '{0, 1, 5, 15, 16, 17, 255, 256, 300};
                int sh;
                sh = (cs == 0) ? 0 : (cs == 1) ? 4 : 8;
                wr(1, 32'h0);
                wr(0, 32'h0);
                wr(1, EN | cs);
                wait_n(ks[j]);
                rd(0, rv);
                check($sformatf("R1 csel%0d k%0d", cs, ks[j]), rv, ks[j] >> sh);
            end
        end

        // R2 stopped count holds
        wr(1, 32'h0);
        rd(0, rv);
        wait_n(20);
        begin
            logic [31:0] prev;
            prev = rv;
            rd(0, rv); check("R2 hold while stopped", rv, prev);
        end

        // R1 hblank clock
        wr(0, 32'h0);
        wr(1, EN | 32'h3);
        repeat (5) hb_pulse();
        wait_n(10);
        rd(0, rv); check("R1 hblank steps", rv, 32'd5);

        // R7 hblank gate ignored with hblank clock
        wr(1, 32'h0);
        wr(0, 32'd7);
        wr(1, EN | 32'h3 | GEN | 32'h10);
        rd(0, rv); check("R7 no clear", rv, 32'd7);
        repeat (3) hb_pulse();
        rd(0, rv); check("R7 ungated count", rv, 32'd10);

        // R8 zero-return periodic
        for (int t = 1; t < 40; t += 12) begin
            wr(1, 32'hC00);
            wr(0, 32'h0);
            wr(2, t);
            irq_cnt = 0;
            wr(1, EN | TIE | ZR);
            wait_n(3 * t);
            rd(0, rv); check($sformatf("R8 zret count t%0d", t), rv, 32'h0);
            check($sformatf("R12 irq pulses t%0d", t), irq_cnt, 3);
            rd(1, rv); check("R8 tflag set", rv[10], 1'b1);
        end

        // R8 no interrupt enable
        wr(1, 32'hC00); wr(0, 32'h0); wr(2, 32'd5);
        irq_cnt = 0;
        wr(1, EN);
        wait_n(12);
        rd(0, rv); check("R8 no ie count", rv, 32'd12);
        rd(1, rv); check("R8 no ie flag", rv[10], 1'b0);
        check("R8 no ie irq", irq_cnt, 0);

        // R8/R9 interrupt without zero-return, fires once
        wr(1, 32'hC00); wr(0, 32'h0); wr(2, 32'd5);
        irq_cnt = 0;
        wr(1, EN | TIE);
        wait_n(12);
        rd(0, rv); check("R8 no zret count", rv, 32'd12);
        check("R9 single fire", irq_cnt, 1);

        // R10 wrap then rearmed target
        wr(1, 32'hC00); wr(0, 32'hFFF0); wr(2, 32'd5);
        irq_cnt = 0;
        wr(1, EN | TIE | OIE);
        wait_n(21);
        rd(0, rv); check("R10 count after wrap", rv, 32'd5);
        check("R10 irq count", irq_cnt, 2);
        rd(1, rv); check("R10 flags", rv[11:10], 2'b11);

        // R3 clear-by-one
        wr(1, 32'h400);
        rd(1, rv); check("R3 clear target flag only", rv, 32'h800);
        wr(1, 32'hF000_0863);
        rd(1, rv); check("R3 low bits stored", rv, 32'h063);

        // R9 deferred targets
        wr(1, 32'hC00); wr(2, 32'd10); wr(0, 32'd20);
        irq_cnt = 0;
        wr(1, EN | TIE);
        wait_n(30);
        rd(0, rv); check("R9 count above target", rv, 32'd50);
        check("R9 count write disarms", irq_cnt, 0);
        wr(1, 32'hC00); wr(2, 32'd40);
        wr(1, EN | TIE);
        wait_n(5);
        rd(0, rv); check("R9 count", rv, 32'd55);
        check("R9 target write disarms", irq_cnt, 0);
        wr(1, 32'hC00); wr(2, 32'd60);
        wr(1, EN | TIE);
        wait_n(15);
        rd(0, rv); check("R9 armed count", rv, 32'd70);
        check("R9 armed fires", irq_cnt, 1);

        // R4/R5/R6 vblank gate styles
        for (int gm = 0; gm < 4; gm++) begin
            wr(1, 32'h0);
            wr(0, 32'd33);
            wr(1, EN | GEN | GVB | (gm << 4));
            wait_n(4);
            rd(0, rv); check($sformatf("R6 suspend gm%0d", gm), rv, exp_g[gm][0]);
            vblank = 1'b1; wait_n(6);
            rd(0, rv); check($sformatf("R5 rise gm%0d", gm), rv, exp_g[gm][1]);
            vblank = 1'b0; wait_n(6);
            rd(0, rv); check($sformatf("R4 fall gm%0d", gm), rv, exp_g[gm][2]);
            vblank = 1'b1; wait_n(6);
            rd(0, rv); check($sformatf("R5 rise2 gm%0d", gm), rv, exp_g[gm][3]);
            vblank = 1'b0; wait_n(2);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule